// File: doc/BRIEF.md
# Synchronous FIFO with Dual-Personality Status Flags

This block is a single-clock first-in first-out buffer whose two main status outputs change meaning depending on a mode chosen while master reset is held. In standard mode a read request moves the oldest stored word onto the data output at the next rising edge. The two status outputs then report "not empty" and "not full". In fall-through mode the oldest word is moved onto the output by itself, with no read request. The status outputs then report "output word valid" and "room for a write". A read request in this mode consumes the word that is already showing.

Three more flags report occupancy. The half flag compares the word count with half the depth. The almost-empty flag compares the count with an empty offset. The almost-full flag compares the number of free places with a full offset. Both offsets are captured at master reset. A timing option, also captured at master reset, selects one of two behaviours for the almost flags:

- immediate: the flags follow the occupancy combinationally;
- registered: the flags lag the occupancy by one clock.

A partial reset empties the buffer and clears the data output, and keeps every captured setting. `DEPTH` must be a power of two.

Top module: `dual_flag_fifo`

## Requirements
- R1: While `mrst_n` is low, every rising edge captures the `cfg_*` inputs. After master reset: `dout_o` is 0, `stat_a_o` is 0, `stat_b_o` is 1, `paf_n_o` is 1, and `pae_n_o` is 0 when the empty offset is non-zero.
- R2: With `cfg_fwft_i`=0 (standard mode), each accepted `rd_en_i` places the oldest word on `dout_o` after that rising edge, in write order. `stat_a_o` is 1 whenever at least one word is stored.
- R3: In standard mode, `stat_b_o` is 0 when `DEPTH` words are stored. A write while full is dropped and corrupts no stored word.
- R4: A read while nothing is available is ignored. `dout_o` holds its value, and later writes and reads keep their order.
- R5: With `cfg_fwft_i`=1 (fall-through mode), a word written to an empty buffer reaches `dout_o` and sets `stat_a_o` at the rising edge after the one that stored it, with no read. A read takes the showing word and presents the next one at the same edge.
- R6: In fall-through mode the capacity is `DEPTH`+1, counting the output word. `stat_b_o` stays 1 while the internal store holds fewer than `DEPTH` words.
- R7: `pae_n_o` is 0 when the occupancy is below the empty offset, and 1 otherwise. In fall-through mode the occupancy includes the word shown at the output.
- R8: `paf_n_o` is 0 when the free places (capacity minus occupancy) are at or below the full offset, and 1 otherwise.
- R9: `half_n_o` is 0 when the occupancy exceeds `DEPTH`/2, and 1 otherwise.
- R10: With `cfg_sync_pflag_i`=1, `pae_n_o` and `paf_n_o` reflect the occupancy one clock later than in the immediate option (`cfg_sync_pflag_i`=0).
- R11: A partial reset (`prst_n` low at a rising edge) empties the buffer and clears `dout_o` to 0. It keeps the mode and both offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low, asserted asynchronously |
| prst_n | input | 1 | Partial reset, active low, sampled on the clock |
| cfg_fwft_i | input | 1 | Mode captured at master reset: 1 = fall-through, 0 = standard |
| cfg_sync_pflag_i | input | 1 | Almost-flag timing captured at master reset: 1 = registered, 0 = immediate |
| cfg_empty_ofs_i | input | OCW | Empty offset captured at master reset |
| cfg_full_ofs_i | input | OCW | Full offset captured at master reset |
| wr_en_i | input | 1 | Write request |
| din_i | input | DW | Write data |
| rd_en_i | input | 1 | Read request |
| dout_o | output | DW | Output data register |
| stat_a_o | output | 1 | Not-empty (standard) or output-valid (fall-through) |
| stat_b_o | output | 1 | Not-full (standard) or input-ready (fall-through) |
| half_n_o | output | 1 | Low when more than half full |
| pae_n_o | output | 1 | Almost-empty flag, active low |
| paf_n_o | output | 1 | Almost-full flag, active low |

## Verification
The hardest state to reach is a fall-through buffer holding `DEPTH`+1 words. Only then does the input-ready flag drop while a word sits in the output register. The bench reaches it with an unbroken run of writes with no reads, so the first word moves into the output stage while the store keeps filling, and it samples after both the sixteenth and the seventeenth write. Reaching the offsets retained across a partial reset needs a fill, a partial reset in the middle of the stream, and a refill to exactly the captured empty offset.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;

  typedef struct packed {
    fifo_mode_e mode;
    logic       sync_pf;
  } fifo_cfg_t;

endpackage

// File: rtl/fifo_ptr_ctl.sv
module fifo_ptr_ctl #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] cnt
);

  logic [AW-1:0] wr_ptr_d, rd_ptr_d;
  logic [CW-1:0] cnt_d;
  logic          is_full, is_empty;

  assign is_full  = (cnt == CW'(DEPTH));
  assign is_empty = (cnt == '0);
  assign push_ok  = push_req && !is_full;
  assign pop_ok   = pop_req && !is_empty;

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    cnt_d    = cnt;
    if (push_ok) wr_ptr_d = wr_ptr + AW'(1);
    if (pop_ok)  rd_ptr_d = rd_ptr + AW'(1);
    unique case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt + CW'(1);
      2'b01:   cnt_d = cnt - CW'(1);
      default: cnt_d = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (!prst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      cnt    <= cnt_d;
    end
  end

  // R3: the stored count never exceeds the depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!mrst_n)
    cnt <= CW'(DEPTH));

  // R3: a write into a full store moves nothing
  p_full_hold_r3: assert property (@(posedge clk) disable iff (!mrst_n)
    (push_req && !pop_req && is_full && prst_n) |=> (is_full && $stable(wr_ptr)));

  // R4: a read from an empty store moves nothing
  p_empty_hold_r4: assert property (@(posedge clk) disable iff (!mrst_n)
    (pop_req && !push_req && is_empty && prst_n) |=> (is_empty && $stable(rd_ptr)));

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 18,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/fifo_flag_gen.sv
module fifo_flag_gen
  import fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OCW   = 5
) (
  input  logic           clk,
  input  logic           mrst_n,
  input  logic           prst_n,
  input  fifo_cfg_t      cfg,
  input  logic [OCW-1:0] empty_ofs,
  input  logic [OCW-1:0] full_ofs,
  input  logic [OCW-1:0] occ,
  output logic           half_n_o,
  output logic           pae_n_o,
  output logic           paf_n_o
);

  localparam int HALF = DEPTH / 2;

  logic [OCW-1:0] cap, free_cnt;
  logic           pae_c, paf_c;
  logic           pae_q, paf_q;

  assign cap      = OCW'(DEPTH) + OCW'(cfg.mode == MODE_FWFT);
  assign free_cnt = cap - occ;
  assign pae_c    = (occ >= empty_ofs);
  assign paf_c    = (free_cnt > full_ofs);
  assign half_n_o = (occ <= OCW'(HALF));

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      pae_q <= 1'b0;
      paf_q <= 1'b1;
    end else if (!prst_n) begin
      pae_q <= 1'b0;
      paf_q <= 1'b1;
    end else begin
      pae_q <= pae_c;
      paf_q <= paf_c;
    end
  end

  assign pae_n_o = cfg.sync_pf ? pae_q : pae_c;
  assign paf_n_o = cfg.sync_pf ? paf_q : paf_c;

  // R10: in registered timing, a rise of almost-empty follows an occupancy already at the offset
  p_pae_lag_r10: assert property (@(posedge clk) disable iff (!mrst_n)
    (cfg.sync_pf && $rose(pae_n_o)) |-> ($past(occ) >= $past(empty_ofs)));

  // R8: in registered timing, a fall of almost-full follows a free count at or below the offset
  p_paf_lag_r8: assert property (@(posedge clk) disable iff (!mrst_n)
    (cfg.sync_pf && prst_n && $fell(paf_n_o)) |-> ($past(free_cnt) <= $past(full_ofs)));

endmodule

// File: rtl/dual_flag_fifo.sv
module dual_flag_fifo
  import fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 18,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int OCW  = $clog2(DEPTH + 2)
) (
  input  logic           clk,
  input  logic           mrst_n,
  input  logic           prst_n,
  input  logic           cfg_fwft_i,
  input  logic           cfg_sync_pflag_i,
  input  logic [OCW-1:0] cfg_empty_ofs_i,
  input  logic [OCW-1:0] cfg_full_ofs_i,
  input  logic           wr_en_i,
  input  logic [DW-1:0]  din_i,
  input  logic           rd_en_i,
  output logic [DW-1:0]  dout_o,
  output logic           stat_a_o,
  output logic           stat_b_o,
  output logic           half_n_o,
  output logic           pae_n_o,
  output logic           paf_n_o
);

  // configuration captured on every edge while master reset is held
  fifo_cfg_t      cfg_q;
  logic [OCW-1:0] empty_ofs_q, full_ofs_q;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      cfg_q.mode    <= cfg_fwft_i ? MODE_FWFT : MODE_STD;
      cfg_q.sync_pf <= cfg_sync_pflag_i;
      empty_ofs_q   <= cfg_empty_ofs_i;
      full_ofs_q    <= cfg_full_ofs_i;
    end
  end

  logic           fwft;
  logic           pop_req, push_ok, pop_ok;
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  mem_cnt;
  logic [DW-1:0]  rd_data;
  logic [DW-1:0]  dout_q, dout_d;
  logic           ov_q, ov_d;
  logic [OCW-1:0] occ;

  assign fwft = (cfg_q.mode == MODE_FWFT);

  fifo_ptr_ctl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptr (
    .clk      (clk),
    .mrst_n   (mrst_n),
    .prst_n   (prst_n),
    .push_req (wr_en_i),
    .pop_req  (pop_req),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .cnt      (mem_cnt)
  );

  fifo_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .clk     (clk),
    .wr_en   (push_ok),
    .wr_addr (wr_ptr),
    .wr_data (din_i),
    .rd_addr (rd_ptr),
    .rd_data (rd_data)
  );

  // output stage: fall-through refills whenever its register is free or being taken
  always_comb begin
    pop_req = fwft ? (!ov_q || rd_en_i) : rd_en_i;
    dout_d  = dout_q;
    ov_d    = ov_q;
    if (pop_ok) begin
      dout_d = rd_data;
      ov_d   = fwft;
    end else if (fwft && rd_en_i) begin
      ov_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      dout_q <= '0;
      ov_q   <= 1'b0;
    end else if (!prst_n) begin
      dout_q <= '0;
      ov_q   <= 1'b0;
    end else begin
      dout_q <= dout_d;
      ov_q   <= ov_d;
    end
  end

  assign occ = OCW'(mem_cnt) + OCW'(fwft && ov_q);

  fifo_flag_gen #(.DEPTH(DEPTH), .OCW(OCW)) u_flags (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .prst_n    (prst_n),
    .cfg       (cfg_q),
    .empty_ofs (empty_ofs_q),
    .full_ofs  (full_ofs_q),
    .occ       (occ),
    .half_n_o  (half_n_o),
    .pae_n_o   (pae_n_o),
    .paf_n_o   (paf_n_o)
  );

  assign dout_o   = dout_q;
  assign stat_a_o = fwft ? ov_q : (mem_cnt != '0);
  assign stat_b_o = (mem_cnt != CW'(DEPTH));

  // R5: a word waiting in the store falls into an idle output register at the next edge
  p_fall_through_r5: assert property (@(posedge clk) disable iff (!mrst_n)
    (fwft && !ov_q && (mem_cnt != '0) && prst_n) |=> ov_q);

  // R2: standard mode never marks the output register as holding a fallen word
  p_std_no_fall_r2: assert property (@(posedge clk) disable iff (!mrst_n)
    (!fwft && $past(!fwft)) |-> !ov_q);

  // R11: a partial reset leaves an empty buffer and a cleared output
  p_partial_clear_r11: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> (!stat_a_o && (dout_o == '0)));

endmodule

// File: tb/dual_flag_fifo_bench.sv
module dual_flag_fifo_bench;

  localparam int DEPTH = 16;
  localparam int DW    = 18;
  localparam int OCW   = $clog2(DEPTH + 2);

  logic           clk;
  logic           mrst_n, prst_n;
  logic           cfg_fwft, cfg_sync;
  logic [OCW-1:0] cfg_eofs, cfg_fofs;
  logic           wr_en, rd_en;
  logic [DW-1:0]  din;
  logic [DW-1:0]  dout;
  logic           stat_a, stat_b, half_n, pae_n, paf_n;

  int n_chk  = 0;
  int n_fail = 0;

  dual_flag_fifo #(.DEPTH(DEPTH), .DW(DW)) u_dual_flag_fifo (
    .clk              (clk),
    .mrst_n           (mrst_n),
    .prst_n           (prst_n),
    .cfg_fwft_i       (cfg_fwft),
    .cfg_sync_pflag_i (cfg_sync),
    .cfg_empty_ofs_i  (cfg_eofs),
    .cfg_full_ofs_i   (cfg_fofs),
    .wr_en_i          (wr_en),
    .din_i            (din),
    .rd_en_i          (rd_en),
    .dout_o           (dout),
    .stat_a_o         (stat_a),
    .stat_b_o         (stat_b),
    .half_n_o         (half_n),
    .pae_n_o          (pae_n),
    .paf_n_o          (paf_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // inputs change at the falling edge; outputs are read at the next falling edge
  task automatic step(input logic we, input logic [DW-1:0] d, input logic re);
    wr_en = we;
    din   = d;
    rd_en = re;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
  endtask

  task automatic mreset(input logic fw, input logic sy, input int eo, input int fo);
    @(negedge clk);
    cfg_fwft = fw;
    cfg_sync = sy;
    cfg_eofs = OCW'(eo);
    cfg_fofs = OCW'(fo);
    mrst_n   = 1'b0;
    prst_n   = 1'b1;
    wr_en    = 1'b0;
    rd_en    = 1'b0;
    repeat (3) @(negedge clk);
    mrst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    mreset(1'b0, 1'b0, 2, 2);
    chk("R1 dout after master reset", 32'(dout), 0);
    chk("R1 stat_a after master reset", 32'(stat_a), 0);
    chk("R1 stat_b after master reset", 32'(stat_b), 1);
    chk("R1 pae_n after master reset", 32'(pae_n), 0);
    chk("R1 paf_n after master reset", 32'(paf_n), 1);
  endtask

  task automatic t_std_order();
    mreset(1'b0, 1'b0, 2, 2);
    step(1'b1, 18'h100, 1'b0);
    chk("R7 pae_n at count 1 below offset 2", 32'(pae_n), 0);
    chk("R2 stat_a with one word", 32'(stat_a), 1);
    step(1'b1, 18'h101, 1'b0);
    chk("R7 pae_n at count 2 equal offset", 32'(pae_n), 1);
    for (int i = 2; i < 5; i++) step(1'b1, DW'(18'h100 + i), 1'b0);
    for (int i = 0; i < 5; i++) begin
      step(1'b0, '0, 1'b1);
      chk($sformatf("R2 read %0d data", i), 32'(dout), 32'(18'h100 + i));
    end
    chk("R2 stat_a after draining", 32'(stat_a), 0);
  endtask

  task automatic t_full_and_empty();
    mreset(1'b0, 1'b0, 2, 2);
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, DW'(18'h200 + i), 1'b0);
      if (i == 7)  chk("R9 half_n at 8 words", 32'(half_n), 1);
      if (i == 8)  chk("R9 half_n at 9 words", 32'(half_n), 0);
      if (i == 12) chk("R8 paf_n with 3 free", 32'(paf_n), 1);
      if (i == 13) chk("R8 paf_n with 2 free", 32'(paf_n), 0);
      if (i == 14) chk("R3 stat_b at 15 words", 32'(stat_b), 1);
    end
    chk("R3 stat_b when full", 32'(stat_b), 0);
    step(1'b1, 18'h3FFFF, 1'b0);
    chk("R3 stat_b after write while full", 32'(stat_b), 0);
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b0, '0, 1'b1);
      chk($sformatf("R3 read %0d after dropped write", i), 32'(dout), 32'(18'h200 + i));
    end
    chk("R4 stat_a when drained", 32'(stat_a), 0);
    step(1'b0, '0, 1'b1);
    chk("R4 dout held on empty read", 32'(dout), 32'h20F);
    chk("R4 stat_a after empty read", 32'(stat_a), 0);
    step(1'b1, 18'h0ABC, 1'b0);
    step(1'b0, '0, 1'b1);
    chk("R4 order intact after empty read", 32'(dout), 32'h0ABC);
  endtask

  task automatic t_fall_through();
    mreset(1'b1, 1'b0, 3, 4);
    chk("R1 fwft stat_a after reset", 32'(stat_a), 0);
    chk("R1 fwft stat_b after reset", 32'(stat_b), 1);
    step(1'b1, 18'h111, 1'b0);
    chk("R5 stat_a at storing edge", 32'(stat_a), 0);
    step(1'b0, '0, 1'b0);
    chk("R5 stat_a one edge later", 32'(stat_a), 1);
    chk("R5 word falls through", 32'(dout), 32'h111);
    chk("R7 fwft pae_n at occupancy 1", 32'(pae_n), 0);
    step(1'b1, 18'h222, 1'b0);
    step(1'b1, 18'h333, 1'b0);
    chk("R7 fwft pae_n counts output word", 32'(pae_n), 1);
    chk("R5 head stays without read", 32'(dout), 32'h111);
    step(1'b0, '0, 1'b1);
    chk("R5 read presents next word", 32'(dout), 32'h222);
    chk("R5 stat_a still valid", 32'(stat_a), 1);
    step(1'b0, '0, 1'b1);
    chk("R5 third word", 32'(dout), 32'h333);
    step(1'b0, '0, 1'b1);
    chk("R5 stat_a after last read", 32'(stat_a), 0);
    for (int i = 1; i <= DEPTH + 1; i++) begin
      step(1'b1, DW'(18'h300 + i), 1'b0);
      if (i == 12) chk("R8 fwft paf_n with 5 free", 32'(paf_n), 1);
      if (i == 13) chk("R8 fwft paf_n with 4 free", 32'(paf_n), 0);
      if (i == DEPTH) chk("R6 stat_b at DEPTH words", 32'(stat_b), 1);
    end
    chk("R6 stat_b at DEPTH+1 words", 32'(stat_b), 0);
  endtask

  task automatic t_partial_reset();
    // continues from the full fall-through state left by t_fall_through
    prst_n = 1'b0;
    step(1'b0, '0, 1'b0);
    prst_n = 1'b1;
    chk("R11 stat_a after partial reset", 32'(stat_a), 0);
    chk("R11 dout after partial reset", 32'(dout), 0);
    chk("R11 stat_b after partial reset", 32'(stat_b), 1);
    chk("R11 pae_n after partial reset", 32'(pae_n), 0);
    step(1'b1, 18'h444, 1'b0);
    chk("R11 still fall-through latency", 32'(stat_a), 0);
    step(1'b0, '0, 1'b0);
    chk("R11 fall-through mode kept", 32'(dout), 32'h444);
    step(1'b1, 18'h445, 1'b0);
    chk("R11 pae_n below kept offset", 32'(pae_n), 0);
    step(1'b1, 18'h446, 1'b0);
    chk("R11 pae_n at kept offset 3", 32'(pae_n), 1);
  endtask

  task automatic t_registered_flags();
    mreset(1'b0, 1'b1, 1, 2);
    step(1'b0, '0, 1'b0);
    chk("R10 pae_n empty", 32'(pae_n), 0);
    step(1'b1, 18'h055, 1'b0);
    chk("R10 pae_n lags the write", 32'(pae_n), 0);
    step(1'b0, '0, 1'b0);
    chk("R10 pae_n one clock later", 32'(pae_n), 1);
    step(1'b0, '0, 1'b1);
    chk("R10 pae_n lags the read", 32'(pae_n), 1);
    step(1'b0, '0, 1'b0);
    chk("R10 pae_n falls one clock later", 32'(pae_n), 0);
  endtask

  initial begin
    mrst_n = 1'b0;
    prst_n = 1'b1;
    wr_en  = 1'b0;
    rd_en  = 1'b0;
    din    = '0;
    t_reset_state();
    t_std_order();
    t_full_and_empty();
    t_fall_through();
    t_partial_reset();
    t_registered_flags();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule